// File: doc/BRIEF.md
# DMA Command Ring Pointer Controller

This block keeps the pointer state for one asynchronous DMA command ring. Software places the ring anywhere in a 40-bit space on a 256-byte boundary, chooses its length as a power-of-two number of dwords, and moves a write pointer forward as it adds commands. The fetch side pulses a consume strobe for every dword it takes. The block moves the read pointer forward on each accepted strobe and wraps it at the end of the ring. It reports when the ring is empty, gives the fetch side the byte address of the next dword, and can copy the read pointer to a programmable memory location whenever the pointer changes.

Both pointers are byte offsets. Only bits 17:2 are held, so software reads them as dword indices shifted left by two. A soft reset input stops the ring and clears both pointers and the control word. The base and writeback addresses survive a soft reset. The usual bring-up is to pulse soft reset, write zero to both pointers, program base, size and writeback address, and set the enable bit last.

A three-state machine summarises the ring. ST_OFF means the enable bit is clear. ST_EMPTY means the ring is enabled and the pointers are equal. ST_ACTIVE means the ring is enabled and the pointers differ. The transitions are enable-on (ST_OFF to ST_EMPTY or ST_ACTIVE, depending on the pointers), refill (ST_EMPTY to ST_ACTIVE on a write-pointer or read-pointer change), drain (ST_ACTIVE to ST_EMPTY when the pointers meet) and stop (any state to ST_OFF on enable-off or soft reset). The state register always agrees with the pointer and control registers in the same cycle. A strobe is therefore accepted only in ST_ACTIVE.

Top module: `dma_ring_ctrl`

## Requirements
- R1: After rst_n is low, every register reads zero, ring_ready and wb_req are 0, and ring_empty is 1.
- R2: Register 2 (read pointer) and register 3 (write pointer) keep only bits 17:2 of a write. Writing 0xFFFFFFFF reads back 0x0003FFFC. Register indices that are not mapped (6 and 7) read zero.
- R3: Register 0 (control) holds the enable in bit 0, the log2 ring size in dwords in bits 5:1, and the writeback enable in bit 12. Its other bits read 0. Register 1 holds the base address divided by 256, all 32 bits. fetch_addr equals base*256 + 4*read pointer.
- R4: Register 4 (writeback low) keeps bits 31:2 and reads 0 in bits 1:0. Register 5 (writeback high) keeps bits 7:0. wb_addr is {high[7:0], low[31:2], 2'b00}.
- R5: When the ring is enabled and the pointers differ, a consume strobe moves the read pointer forward by one dword, visible on the following cycle. In all other cases the strobe has no effect.
- R6: The read pointer wraps modulo 2^n dwords, where n is the size field capped at 16. With n=3, the pointer goes from dword 7 to dword 0. With n=0, it stays at 0.
- R7: ring_empty is 1 exactly when the read pointer equals the write pointer. ring_ready is 1 exactly when the ring is enabled and not empty. Both follow a register change by one cycle.
- R8: With writeback enabled, every change of the read pointer raises wb_req for one cycle, in the cycle the new value first reads back. During that cycle wb_data holds the new pointer in byte form. Writeback disabled, or a pointer that does not change, raises no request.
- R9: A one-cycle soft_rst pulse clears the control register and both pointers, keeps the base and writeback addresses, and raises no writeback request.
- R10: Once the enable bit is cleared, consume strobes leave the read pointer unchanged.
- R11: A software write to the read pointer in the same cycle as an accepted consume strobe wins. The pointer takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous engine reset: clears control and both pointers |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| consume | input | 1 | Fetch side took one dword |
| ring_ready | output | 1 | Ring enabled and holding unconsumed dwords |
| ring_empty | output | 1 | Read pointer equals write pointer |
| fetch_addr | output | 40 | Byte address of the next dword to fetch |
| wb_req | output | 1 | One-cycle read-pointer writeback request |
| wb_addr | output | 40 | Writeback byte address |
| wb_data | output | 32 | Read pointer in byte form for writeback |

## Verification
A state machine that lags or leads the pointers shows up on the next cycle in one of two ways. Either ring_ready stays high while ring_empty is high and an extra strobe pushes the read pointer past the write pointer, or ring_ready stays low for one more cycle after a refill. A wrong wrap mask shows up at the first strobe at the end of the ring, when the read pointer reads back a non-zero dword index. A corrupt writeback path shows up in the very cycle the pointer changes, as a missing wb_req, a request with the pointer unchanged, or wb_data that differs from the read-pointer register. Soft reset and write-versus-consume priority are each visible on the register read port one cycle after the colliding edge.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_EMPTY  = 2'd1,
        ST_ACTIVE = 2'd2
    } ring_state_e;

    localparam int          REG_IDX_W   = 3;
    localparam logic [2:0]  RA_CTRL     = 3'd0;
    localparam logic [2:0]  RA_BASE     = 3'd1;
    localparam logic [2:0]  RA_RPTR     = 3'd2;
    localparam logic [2:0]  RA_WPTR     = 3'd3;
    localparam logic [2:0]  RA_WBLO     = 3'd4;
    localparam logic [2:0]  RA_WBHI     = 3'd5;

    localparam int          CTRL_EN_BIT = 0;
    localparam int          CTRL_SZ_LSB = 1;
    localparam int          CTRL_SZ_W   = 5;
    localparam int          CTRL_WB_BIT = 12;

    localparam int          PTR_LSB     = 2;

endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
    import dma_ring_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_HI_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      wen,
    input  logic [REG_IDX_W-1:0]      addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic                      en_d,
    output logic                      en_q,
    output logic                      wben_d,
    output logic                      wben_q,
    output logic [CTRL_SZ_W-1:0]      sz_q,
    output logic [DATA_W-1:0]         base_q,
    output logic [PTR_W-1:0]          wptr_d,
    output logic [PTR_W-1:0]          wptr_q,
    output logic [DATA_W-3:0]         wblo_q,
    output logic [ADDR_HI_W-1:0]      wbhi_q
);

    logic [CTRL_SZ_W-1:0] sz_d;
    logic [DATA_W-1:0]    base_d;
    logic [DATA_W-3:0]    wblo_d;
    logic [ADDR_HI_W-1:0] wbhi_d;

    // next-value logic: soft reset outranks software writes
    always_comb begin
        en_d   = en_q;
        wben_d = wben_q;
        sz_d   = sz_q;
        base_d = base_q;
        wptr_d = wptr_q;
        wblo_d = wblo_q;
        wbhi_d = wbhi_q;
        if (soft_rst) begin
            en_d   = 1'b0;
            wben_d = 1'b0;
            sz_d   = '0;
            wptr_d = '0;
        end else if (wen) begin
            case (addr)
                RA_CTRL: begin
                    en_d   = wdata[CTRL_EN_BIT];
                    sz_d   = wdata[CTRL_SZ_LSB +: CTRL_SZ_W];
                    wben_d = wdata[CTRL_WB_BIT];
                end
                RA_BASE: base_d = wdata;
                RA_WPTR: wptr_d = wdata[PTR_LSB +: PTR_W];
                RA_WBLO: wblo_d = wdata[DATA_W-1:2];
                RA_WBHI: wbhi_d = wdata[ADDR_HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            wben_q <= 1'b0;
            sz_q   <= '0;
            base_q <= '0;
            wptr_q <= '0;
            wblo_q <= '0;
            wbhi_q <= '0;
        end else begin
            en_q   <= en_d;
            wben_q <= wben_d;
            sz_q   <= sz_d;
            base_q <= base_d;
            wptr_q <= wptr_d;
            wblo_q <= wblo_d;
            wbhi_q <= wbhi_d;
        end
    end

endmodule

// File: rtl/dma_ring_rptr.sv
module dma_ring_rptr #(
    parameter int PTR_W = 16,
    parameter int SZ_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             sw_wr,
    input  logic [PTR_W-1:0] sw_val,
    input  logic             step,
    input  logic [SZ_W-1:0]  sz,
    output logic [PTR_W-1:0] rptr_d,
    output logic [PTR_W-1:0] rptr_q
);

    logic [PTR_W-1:0] wrap_mask;

    // bit g of the mask is set when the ring holds more than 2^g dwords;
    // a size field above PTR_W saturates to all ones
    for (genvar g = 0; g < PTR_W; g++) begin : g_mask
        assign wrap_mask[g] = (int'(sz) > g);
    end

    always_comb begin
        if (soft_rst)
            rptr_d = '0;
        else if (sw_wr)
            rptr_d = sw_val;
        else if (step)
            rptr_d = (rptr_q + PTR_W'(1)) & wrap_mask;
        else
            rptr_d = rptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rptr_q <= '0;
        else
            rptr_q <= rptr_d;
    end

endmodule

// File: rtl/dma_ring_fsm.sv
module dma_ring_fsm
    import dma_ring_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_d,
    input  logic [PTR_W-1:0] rptr_d,
    input  logic [PTR_W-1:0] wptr_d,
    output logic             ready
);

    ring_state_e state_q;
    ring_state_e state_d;
    logic        meet_d;

    assign meet_d = (rptr_d == wptr_d);

    // transitions are taken from next register values, so the state
    // always agrees with the pointers held in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_d)
                    state_d = meet_d ? ST_EMPTY : ST_ACTIVE;   // enable-on
            end
            ST_EMPTY: begin
                if (!en_d)
                    state_d = ST_OFF;                           // stop
                else if (!meet_d)
                    state_d = ST_ACTIVE;                        // refill
            end
            ST_ACTIVE: begin
                if (!en_d)
                    state_d = ST_OFF;                           // stop
                else if (meet_d)
                    state_d = ST_EMPTY;                         // drain
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        ready = (state_q == ST_ACTIVE);
    end

endmodule

// File: rtl/dma_ring_wb.sv
module dma_ring_wb #(
    parameter int PTR_W     = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_HI_W = 8,
    parameter int ADDR_W    = DATA_W + ADDR_HI_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 wben_d,
    input  logic [PTR_W-1:0]     rptr_d,
    input  logic [PTR_W-1:0]     rptr_q,
    input  logic [DATA_W-3:0]    wblo_q,
    input  logic [ADDR_HI_W-1:0] wbhi_q,
    output logic                 wb_req,
    output logic [ADDR_W-1:0]    wb_addr,
    output logic [DATA_W-1:0]    wb_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wb_req <= 1'b0;
        else
            wb_req <= !soft_rst && wben_d && (rptr_d != rptr_q);
    end

    assign wb_addr = {wbhi_q, wblo_q, 2'b00};
    assign wb_data = DATA_W'({rptr_q, 2'b00});

endmodule

// File: rtl/dma_ring_ctrl.sv
module dma_ring_ctrl
    import dma_ring_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_HI_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soft_rst,
    input  logic                        reg_wen,
    input  logic [2:0]                  reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic                        consume,
    output logic                        ring_ready,
    output logic                        ring_empty,
    output logic [DATA_W+ADDR_HI_W-1:0] fetch_addr,
    output logic                        wb_req,
    output logic [DATA_W+ADDR_HI_W-1:0] wb_addr,
    output logic [DATA_W-1:0]           wb_data
);

    localparam int ADDR_W = DATA_W + ADDR_HI_W;

    logic                 en_d, en_q, wben_d, wben_q;
    logic [CTRL_SZ_W-1:0] sz_q;
    logic [DATA_W-1:0]    base_q;
    logic [PTR_W-1:0]     wptr_d, wptr_q, rptr_d, rptr_q;
    logic [DATA_W-3:0]    wblo_q;
    logic [ADDR_HI_W-1:0] wbhi_q;
    logic                 rptr_sw_wr;
    logic                 step;

    dma_ring_regs #(
        .PTR_W     (PTR_W),
        .DATA_W    (DATA_W),
        .ADDR_HI_W (ADDR_HI_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wen      (reg_wen),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .en_d     (en_d),
        .en_q     (en_q),
        .wben_d   (wben_d),
        .wben_q   (wben_q),
        .sz_q     (sz_q),
        .base_q   (base_q),
        .wptr_d   (wptr_d),
        .wptr_q   (wptr_q),
        .wblo_q   (wblo_q),
        .wbhi_q   (wbhi_q)
    );

    assign rptr_sw_wr = reg_wen && (reg_addr == RA_RPTR);
    assign step       = consume && ring_ready;

    dma_ring_rptr #(
        .PTR_W (PTR_W),
        .SZ_W  (CTRL_SZ_W)
    ) u_rptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .sw_wr    (rptr_sw_wr),
        .sw_val   (reg_wdata[PTR_LSB +: PTR_W]),
        .step     (step),
        .sz       (sz_q),
        .rptr_d   (rptr_d),
        .rptr_q   (rptr_q)
    );

    dma_ring_fsm #(
        .PTR_W (PTR_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_d   (en_d),
        .rptr_d (rptr_d),
        .wptr_d (wptr_d),
        .ready  (ring_ready)
    );

    dma_ring_wb #(
        .PTR_W     (PTR_W),
        .DATA_W    (DATA_W),
        .ADDR_HI_W (ADDR_HI_W),
        .ADDR_W    (ADDR_W)
    ) u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wben_d   (wben_d),
        .rptr_d   (rptr_d),
        .rptr_q   (rptr_q),
        .wblo_q   (wblo_q),
        .wbhi_q   (wbhi_q),
        .wb_req   (wb_req),
        .wb_addr  (wb_addr),
        .wb_data  (wb_data)
    );

    assign ring_empty = (rptr_q == wptr_q);
    assign fetch_addr = {base_q, {ADDR_HI_W{1'b0}}} + ADDR_W'({rptr_q, 2'b00});

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTRL_EN_BIT]                = en_q;
                reg_rdata[CTRL_SZ_LSB +: CTRL_SZ_W]   = sz_q;
                reg_rdata[CTRL_WB_BIT]                = wben_q;
            end
            RA_BASE: reg_rdata                        = base_q;
            RA_RPTR: reg_rdata[PTR_LSB +: PTR_W]      = rptr_q;
            RA_WPTR: reg_rdata[PTR_LSB +: PTR_W]      = wptr_q;
            RA_WBLO: reg_rdata[DATA_W-1:2]            = wblo_q;
            RA_WBHI: reg_rdata[ADDR_HI_W-1:0]         = wbhi_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_ring_ctrl_chk.sv
module dma_ring_ctrl_chk
    import dma_ring_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              reg_wen,
    input logic [2:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              ring_ready,
    input logic              ring_empty,
    input logic              wb_req,
    input logic [DATA_W-1:0] wb_data,
    input logic [PTR_W-1:0]  rptr
);

    logic sw_rptr;
    assign sw_rptr = reg_wen && (reg_addr == RA_RPTR);

    // R7
    ready_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ready |-> !ring_empty);

    // R10
    idle_rptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_ready && !soft_rst && !sw_rptr) |=> $stable(rptr));

    // R8
    wb_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (rptr != $past(rptr)) && (wb_data[PTR_LSB +: PTR_W] == rptr));

    // R9
    soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ring_empty && !ring_ready && !wb_req);

    // R11
    sw_rptr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rptr && !soft_rst) |=> rptr == $past(reg_wdata[PTR_LSB +: PTR_W]));

endmodule

bind dma_ring_ctrl dma_ring_ctrl_chk #(
    .PTR_W  (PTR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ring_ready (ring_ready),
    .ring_empty (ring_empty),
    .wb_req     (wb_req),
    .wb_data    (wb_data),
    .rptr       (rptr_q)
);

// File: tb/dma_ring_ctrl_bench.sv
`timescale 1ns/1ps
module dma_ring_ctrl_bench;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_CS = 2'd2;
    localparam logic [1:0] OP_ST = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // status word for OP_CS / OP_ST: {wb_req, ring_empty, ring_ready}
    localparam int NVEC = 38;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD, 3'd0, 32'h0,        32'h0,     4'd1},  // R1 control clear
        '{OP_RD, 3'd2, 32'h0,        32'h0,     4'd1},  // R1 pointer clear
        '{OP_ST, 3'd0, 32'h0,        32'h2,     4'd1},  // R1 empty, not ready
        '{OP_WR, 3'd3, 32'hFFFFFFFF, 32'h0,     4'd0},
        '{OP_RD, 3'd3, 32'h0,        32'h3FFFC, 4'd2},  // R2
        '{OP_WR, 3'd2, 32'hFFFFFFFF, 32'h0,     4'd0},
        '{OP_RD, 3'd2, 32'h0,        32'h3FFFC, 4'd2},  // R2
        '{OP_WR, 3'd2, 32'h0,        32'h0,     4'd0},
        '{OP_WR, 3'd3, 32'h0,        32'h0,     4'd0},
        '{OP_WR, 3'd0, 32'hFFFFFFFF, 32'h0,     4'd0},
        '{OP_RD, 3'd0, 32'h0,        32'h103F,  4'd3},  // R3 field layout
        '{OP_WR, 3'd0, 32'h0,        32'h0,     4'd0},
        '{OP_WR, 3'd1, 32'h12345678, 32'h0,     4'd0},
        '{OP_RD, 3'd1, 32'h0,        32'h12345678, 4'd3}, // R3 base
        '{OP_WR, 3'd4, 32'hABCDEF03, 32'h0,     4'd0},
        '{OP_RD, 3'd4, 32'h0,        32'hABCDEF00, 4'd4}, // R4
        '{OP_WR, 3'd5, 32'h000001FF, 32'h0,     4'd0},
        '{OP_RD, 3'd5, 32'h0,        32'hFF,    4'd4},  // R4
        '{OP_WR, 3'd0, 32'h00001007, 32'h0,     4'd0},  // enable, 8 dwords, writeback
        '{OP_ST, 3'd0, 32'h0,        32'h2,     4'd7},  // R7 enabled but empty
        '{OP_WR, 3'd3, 32'h0000000C, 32'h0,     4'd0},
        '{OP_ST, 3'd0, 32'h0,        32'h1,     4'd7},  // R7 ready
        '{OP_CS, 3'd0, 32'h0,        32'h5,     4'd8},  // R8 request on advance
        '{OP_RD, 3'd2, 32'h0,        32'h4,     4'd5},  // R5
        '{OP_CS, 3'd0, 32'h0,        32'h5,     4'd5},
        '{OP_CS, 3'd0, 32'h0,        32'h6,     4'd7},  // R7 drained
        '{OP_CS, 3'd0, 32'h0,        32'h2,     4'd5},  // R5 strobe while empty
        '{OP_RD, 3'd2, 32'h0,        32'hC,     4'd5},
        '{OP_WR, 3'd3, 32'h00000004, 32'h0,     4'd0},
        '{OP_WR, 3'd2, 32'h0000001C, 32'h0,     4'd0},
        '{OP_CS, 3'd0, 32'h0,        32'h5,     4'd6},  // R6 wrap 7 -> 0
        '{OP_RD, 3'd2, 32'h0,        32'h0,     4'd6},
        '{OP_WR, 3'd0, 32'h00000006, 32'h0,     4'd0},  // disable
        '{OP_CS, 3'd0, 32'h0,        32'h0,     4'd10}, // R10
        '{OP_RD, 3'd2, 32'h0,        32'h0,     4'd10},
        '{OP_WR, 3'd0, 32'h00000007, 32'h0,     4'd0},  // enable, no writeback
        '{OP_CS, 3'd0, 32'h0,        32'h2,     4'd8},  // R8 no request
        '{OP_RD, 3'd6, 32'h0,        32'h0,     4'd2}   // R2 unmapped index
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        consume = 1'b0;
    logic        ring_ready, ring_empty, wb_req;
    logic [39:0] fetch_addr, wb_addr;
    logic [31:0] wb_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_ring_ctrl u_dma_ring_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .consume    (consume),
        .ring_ready (ring_ready),
        .ring_empty (ring_empty),
        .fetch_addr (fetch_addr),
        .wb_req     (wb_req),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_cs();
        @(negedge clk);
        consume = 1'b1;
        @(negedge clk);
        consume = 1'b0;
    endtask

    function automatic logic [31:0] status();
        return {29'b0, wb_req, ring_empty, ring_ready};
    endfunction

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            case (VECS[i].op)
                OP_WR: do_wr(VECS[i].addr, VECS[i].data);
                OP_RD: begin
                    do_rd(VECS[i].addr, rd);
                    check(tag, 64'(rd), 64'(VECS[i].exp));
                end
                OP_CS: begin
                    do_cs();
                    check(tag, 64'(status()), 64'(VECS[i].exp));
                end
                default: begin
                    @(negedge clk);
                    #1 check(tag, 64'(status()), 64'(VECS[i].exp));
                end
            endcase
        end

        // R3 fetch address: base 0x12345678, read pointer dword 1
        check("R3 fetch_addr", 64'(fetch_addr), 64'h12_3456_7804);

        // R8 writeback payload and R4 address
        do_wr(3'd0, 32'h00001007);
        do_wr(3'd3, 32'h00000010);
        do_cs();
        check("R8 wb_req", 64'(wb_req), 64'd1);
        check("R8 wb_data", 64'(wb_data), 64'h8);
        check("R4 wb_addr", 64'(wb_addr), 64'hFF_ABCD_EF00);

        // R11 software write beats a simultaneous accepted consume
        @(negedge clk);
        consume = 1'b1; reg_wen = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h14;
        @(negedge clk);
        consume = 1'b0; reg_wen = 1'b0;
        do_rd(3'd2, rd);
        check("R11 rptr", 64'(rd), 64'h14);

        // R9 soft reset
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        check("R9 no wb_req", 64'(wb_req), 64'd0);
        check("R9 status", 64'(status()), 64'h2);
        do_rd(3'd0, rd); check("R9 ctrl", 64'(rd), 64'h0);
        do_rd(3'd2, rd); check("R9 rptr", 64'(rd), 64'h0);
        do_rd(3'd3, rd); check("R9 wptr", 64'(rd), 64'h0);
        do_rd(3'd1, rd); check("R9 base kept", 64'(rd), 64'h12345678);
        do_rd(3'd5, rd); check("R9 wb hi kept", 64'(rd), 64'hFF);

        // R6 size field above 16 saturates to a full 16-bit wrap
        do_wr(3'd0, 32'h00000029);
        do_wr(3'd3, 32'h00000004);
        do_wr(3'd2, 32'h0003FFFC);
        do_cs();
        do_rd(3'd2, rd); check("R6 wide wrap", 64'(rd), 64'h0);
        // R6 one-dword ring stays at zero
        do_wr(3'd0, 32'h00000001);
        do_cs();
        do_rd(3'd2, rd); check("R6 size one", 64'(rd), 64'h0);
        check("R6 still ready", 64'(status()), 64'h1);

        // R1 asynchronous reset mid-run
        @(negedge clk) rst_n = 1'b0;
        #1 check("R1 ready low", 64'(ring_ready), 64'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_rd(3'd1, rd); check("R1 base", 64'(rd), 64'h0);
        do_rd(3'd5, rd); check("R1 wb hi", 64'(rd), 64'h0);
        do_rd(3'd0, rd); check("R1 ctrl", 64'(rd), 64'h0);
        check("R1 status", 64'(status()), 64'h2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule